// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block sits between a load/store requester and a word-wide external memory port. Every access it accepts is looked up in a direct-mapped array of tagged lines. A hit is answered from the array. A load hit needs no memory traffic. A store hit writes its word into the line, and also sends the word to memory when the access is marked write-through. On a miss, three conditions decide whether the block may claim a line: the global cache enable, the memory-management enable and the access's own cacheable flag. All three must be set for a line to be allocated.

Turning the cache enable off does not stop lookups. Hits are still served, and store hits still update resident lines. Only the allocation of new lines stops. A load miss that may allocate fills the whole line with sequential word reads. If the victim line is dirty, its words are written back first. Any other miss goes to memory as a single word access. The requester sees one response pulse for each accepted access and is held off by a busy flag while the block talks to memory.

Top module: `dcache_top`

## Requirements
- R1: A load that hits is answered with `resp_valid` and `resp_hit` high in the cycle after acceptance, carrying the stored word, and causes no memory request.
- R2: A store that hits, without write-through, writes its word into the line with no memory request and is answered with `resp_hit` high in the cycle after acceptance; a later load of that address returns the new word.
- R3: A store hit with write-through updates the line and issues exactly one memory write of the same address and data. It leaves the line clean, so evicting that line later causes no write-back.
- R4: A store hit without write-through marks the line dirty. When a dirty line is replaced, its eight words are written to memory at the line's old base address in ascending word order before any fill read is issued.
- R5: With `cache_en` low, load hits still return cached data and store hits still update the cached line, with no memory request.
- R6: A load miss allocates only when `cache_en`, `mmu_en` and `req_cacheable` are all high. Otherwise it performs one memory read at the request address, returns that word with `resp_hit` low, and leaves the array unchanged, so a repeat of the load misses again.
- R7: An allocating load miss issues eight reads at the line base and each following word address in ascending order, returns the requested word with `resp_hit` low, and makes later loads to that line hit.
- R8: A store miss never allocates: it produces one memory write of its address and data and `resp_hit` low, and a later load of that address still misses.
- R9: `req_busy` is high from the cycle after a memory-bound access is accepted until its response. A request presented while busy is ignored. `resp_valid` is never high while busy.
- R10: After reset all lines are invalid and clean, `req_busy`, `resp_valid` and `mem_req_valid` are low, and the first load misses.
- R11: A memory request with `mem_req_valid` high and `mem_req_ready` low keeps valid, address, direction and write data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Global cache enable; gates allocation only |
| mmu_en | input | 1 | Memory-management enable; gates allocation |
| req_valid | input | 1 | Access request; accepted in a cycle where `req_busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store data |
| req_cacheable | input | 1 | Per-access cacheable flag |
| req_wthru | input | 1 | Per-access write-through flag |
| req_busy | output | 1 | High while an accepted access is still waiting on memory |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Access hit a resident line |
| resp_rdata | output | WORD_W | Load data (zero for stores) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | WORD_W | Memory write data |
| mem_rd_valid | input | 1 | Read data strobe for the outstanding read |
| mem_rd_data | input | WORD_W | Read data |

## Verification
The bench keeps the default geometry of 64 lines of eight 32-bit words. Addresses 2 KiB apart therefore fall on the same line, which lets it force evictions of clean and dirty victims with a handful of accesses. The eight-beat lines make the order of write-back and fill transactions visible in the bench's memory log. The memory model can toggle its ready signal every cycle, which exercises request holding and the busy window during long fills.

// File: rtl/dcache_pkg.sv
// Shared types for the data cache controller.
// Assumes: only the controller FSM uses the state encoding.
package dcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // lookup and hit service
        ST_WBACK,    // writing a dirty victim back, one word per handshake
        ST_RD_REQ,   // issuing a read (fill beat or single word)
        ST_RD_WAIT,  // waiting for read data
        ST_WR        // single word write (store miss or write-through)
    } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
// Per-line tag, valid and dirty state for a direct-mapped cache.
// Reads are combinational. A fill write validates the line and clears dirty;
// a dirty set marks the line modified. Assumes the two writes never coincide.
module dcache_tag_store #(
    parameter int NUM_LINES = 64,
    parameter int TAG_W     = 21,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    // Combinational read of the indexed line.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
    end

    // Valid and dirty flags: cleared on reset, updated by fill or store hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag storage written when a fill completes.
    always_ff @(posedge clk) begin
        if (fill_we) tag_q[idx] <= fill_tag;
    end

    // R4: a fill and a dirty marking never collide on the same cycle.
    assert_fill_vs_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !dirty_set);
endmodule

// File: rtl/dcache_data_store.sv
// Word-addressed data array for the cache: combinational read, one write port.
// Assumes LINE_WORDS and NUM_LINES are powers of two.
module dcache_data_store #(
    parameter int NUM_LINES  = 64,
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] word,
    output logic [WORD_W-1:0] rdata,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Read the addressed word.
    assign rdata = mem_q[{idx, word}];

    // Write the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (we) mem_q[{idx, word}] <= wdata;
    end
endmodule

// File: rtl/dcache_ctrl.sv
// Lookup, hit service and miss sequencing for a direct-mapped data cache.
// One access is in flight at a time; one memory read is outstanding at a time.
// Assumes mem_rd_valid only arrives while a read has been accepted.
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 64,
    localparam int BYTE_W    = $clog2(WORD_W / 8),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - WSEL_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              mmu_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic              req_wthru,
    output logic              req_busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic [IDX_W-1:0]  arr_idx,
    output logic [WSEL_W-1:0] arr_word,
    input  logic              ts_valid,
    input  logic              ts_dirty,
    input  logic [TAG_W-1:0]  ts_tag,
    output logic              fill_we,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              dirty_set,
    input  logic [WORD_W-1:0] ds_rdata,
    output logic              ds_we,
    output logic [WORD_W-1:0] ds_wdata
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

    dc_state_e          st;
    logic [ADDR_W-1:0]  r_addr;
    logic [WORD_W-1:0]  r_wdata;
    logic               r_alloc;
    logic               r_hit;
    logic [TAG_W-1:0]   r_vtag;
    logic [WORD_W-1:0]  r_word;
    logic [WSEL_W-1:0]  cnt;
    logic               resp_valid_q;
    logic               resp_hit_q;
    logic [WORD_W-1:0]  resp_data_q;

    logic [TAG_W-1:0]   req_tag, r_tag;
    logic [IDX_W-1:0]   req_idx, r_idx;
    logic [WSEL_W-1:0]  req_wsel, r_wsel;
    logic               accept, hit, alloc_ok, store_hit, rd_beat;

    // Address field split for the incoming request and the captured one.
    always_comb begin
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        req_idx  = req_addr[BYTE_W+WSEL_W +: IDX_W];
        req_wsel = req_addr[BYTE_W +: WSEL_W];
        r_tag    = r_addr[ADDR_W-1 -: TAG_W];
        r_idx    = r_addr[BYTE_W+WSEL_W +: IDX_W];
        r_wsel   = r_addr[BYTE_W +: WSEL_W];
    end

    // Lookup, allocation gating and array write controls.
    always_comb begin
        accept    = (st == ST_IDLE) && req_valid;
        hit       = ts_valid && (ts_tag == req_tag);
        alloc_ok  = cache_en && mmu_en && req_cacheable;
        store_hit = accept && hit && req_write;
        dirty_set = store_hit && !req_wthru;
        rd_beat   = (st == ST_RD_WAIT) && mem_rd_valid && r_alloc;
        arr_idx   = (st == ST_IDLE) ? req_idx  : r_idx;
        arr_word  = (st == ST_IDLE) ? req_wsel : cnt;
        ds_we     = store_hit || rd_beat;
        ds_wdata  = (st == ST_IDLE) ? req_wdata : mem_rd_data;
        fill_we   = rd_beat && (cnt == LAST_WORD);
        fill_tag  = r_tag;
    end

    // Memory request drive, a pure function of state so it holds while stalled.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (st)
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {r_vtag, r_idx, cnt, {BYTE_W{1'b0}}};
                mem_req_wdata = ds_rdata;
            end
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_alloc ? {r_tag, r_idx, cnt, {BYTE_W{1'b0}}} : r_addr;
            end
            ST_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = r_addr;
                mem_req_wdata = r_wdata;
            end
            default: ;
        endcase
    end

    // Access sequencing and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            r_addr       <= '0;
            r_wdata      <= '0;
            r_alloc      <= 1'b0;
            r_hit        <= 1'b0;
            r_vtag       <= '0;
            r_word       <= '0;
            cnt          <= '0;
            resp_valid_q <= 1'b0;
            resp_hit_q   <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    r_alloc <= alloc_ok;
                    r_hit   <= hit;
                    r_vtag  <= ts_tag;
                    cnt     <= '0;
                    if (hit && !req_write) begin
                        resp_valid_q <= 1'b1;
                        resp_hit_q   <= 1'b1;
                        resp_data_q  <= ds_rdata;
                    end else if (hit && !req_wthru) begin
                        resp_valid_q <= 1'b1;
                        resp_hit_q   <= 1'b1;
                        resp_data_q  <= '0;
                    end else if (req_write) begin
                        st <= ST_WR;
                    end else if (alloc_ok && ts_valid && ts_dirty) begin
                        st <= ST_WBACK;
                    end else begin
                        st <= ST_RD_REQ;
                    end
                end
                ST_WBACK: if (mem_req_ready) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_WORD) st <= ST_RD_REQ;
                end
                ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rd_valid) begin
                    if (!r_alloc) begin
                        resp_valid_q <= 1'b1;
                        resp_hit_q   <= 1'b0;
                        resp_data_q  <= mem_rd_data;
                        st           <= ST_IDLE;
                    end else begin
                        if (cnt == r_wsel) r_word <= mem_rd_data;
                        if (cnt == LAST_WORD) begin
                            resp_valid_q <= 1'b1;
                            resp_hit_q   <= 1'b0;
                            resp_data_q  <= (cnt == r_wsel) ? mem_rd_data : r_word;
                            st           <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= ST_RD_REQ;
                        end
                    end
                end
                ST_WR: if (mem_req_ready) begin
                    resp_valid_q <= 1'b1;
                    resp_hit_q   <= r_hit;
                    resp_data_q  <= '0;
                    st           <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_busy   = (st != ST_IDLE);
    assign resp_valid = resp_valid_q;
    assign resp_hit   = resp_hit_q;
    assign resp_rdata = resp_data_q;

    // R11: a stalled memory request is held unchanged.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    // R9: no completion pulse while the requester is held off.
    assert_resp_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_busy);

    // R1: a load hit answers next cycle without touching memory.
    assert_load_hit_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && !req_write) |=> (resp_valid && resp_hit && !mem_req_valid));

    // R6: write-back and line fill only happen for allocating accesses.
    assert_alloc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WBACK) || fill_we) |-> r_alloc);

    // R4: every write-back beat is a memory write.
    assert_wback_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WBACK) |-> (mem_req_valid && mem_req_write));
endmodule

// File: rtl/dcache_top.sv
// Direct-mapped data cache controller: tag store, data array and sequencer.
// Assumes a single-outstanding-read memory with a valid/ready request channel.
module dcache_top #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 64,
    localparam int BYTE_W    = $clog2(WORD_W / 8),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - WSEL_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              mmu_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic              req_wthru,
    output logic              req_busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data
);
    logic [IDX_W-1:0]  arr_idx;
    logic [WSEL_W-1:0] arr_word;
    logic              ts_valid, ts_dirty, fill_we, dirty_set, ds_we;
    logic [TAG_W-1:0]  ts_tag, fill_tag;
    logic [WORD_W-1:0] ds_rdata, ds_wdata;

    dcache_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W),
        .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .mmu_en(mmu_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cacheable(req_cacheable), .req_wthru(req_wthru),
        .req_busy(req_busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_rdata(resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .arr_idx(arr_idx), .arr_word(arr_word), .ts_valid(ts_valid),
        .ts_dirty(ts_dirty), .ts_tag(ts_tag), .fill_we(fill_we),
        .fill_tag(fill_tag), .dirty_set(dirty_set), .ds_rdata(ds_rdata),
        .ds_we(ds_we), .ds_wdata(ds_wdata)
    );

    dcache_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx), .line_valid(ts_valid),
        .line_dirty(ts_dirty), .line_tag(ts_tag), .fill_we(fill_we),
        .fill_tag(fill_tag), .dirty_set(dirty_set)
    );

    dcache_data_store #(
        .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk), .idx(arr_idx), .word(arr_word), .rdata(ds_rdata),
        .we(ds_we), .wdata(ds_wdata)
    );
endmodule

// File: tb/tb_dcache_top.sv
// Directed bench: one task per scenario, memory model with a transaction log.
module tb_dcache_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1, mmu_en = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0, req_wthru = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_busy, resp_valid, resp_hit;
    logic [31:0] resp_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int errors = 0, checks = 0;
    logic stall = 1'b0;

    // Memory model and transaction log, all updated at the falling edge.
    logic [31:0] mem_w [0:2047];
    logic        inited = 1'b0;
    logic        rd_pend = 1'b0;
    int          rd_cnt = 0;
    logic [10:0] rd_idx = '0;
    logic [31:0] lg_a [0:511];
    logic [31:0] lg_d [0:511];
    logic        lg_w [0:511];
    int          lg_n = 0;

    dcache_top dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .mmu_en(mmu_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cacheable(req_cacheable), .req_wthru(req_wthru),
        .req_busy(req_busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_rdata(resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] initv(input logic [31:0] a);
        return 32'hA5A5_0000 ^ a;
    endfunction

    always @(negedge clk) begin
        logic nr;
        if (!inited) begin
            for (int i = 0; i < 2048; i++) mem_w[i] <= initv(i * 4);
            inited <= 1'b1;
        end
        nr = stall ? ~mem_req_ready : 1'b1;
        mem_req_ready <= nr;
        mem_rd_valid <= 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem_w[rd_idx];
                rd_pend      <= 1'b0;
            end else rd_cnt <= rd_cnt - 1;
        end
        if (mem_req_valid && nr) begin
            if (lg_n < 512) begin
                lg_a[lg_n] <= mem_req_addr;
                lg_d[lg_n] <= mem_req_wdata;
                lg_w[lg_n] <= mem_req_write;
            end
            lg_n <= lg_n + 1;
            if (mem_req_write) mem_w[mem_req_addr[12:2]] <= mem_req_wdata;
            else begin
                rd_pend <= 1'b1;
                rd_cnt  <= 1;
                rd_idx  <= mem_req_addr[12:2];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; hold_off drives a conflicting store while the block is busy.
    task automatic acc(input logic w, input logic [31:0] a, input logic [31:0] d,
                       input logic c, input logic wt, input bit hold_off,
                       output logic [31:0] rd, output logic h, output int lat,
                       output int nops, output int base, output int busy_cyc);
        @(negedge clk);
        base = lg_n;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        req_cacheable = c; req_wthru = wt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_cyc = 0;
        while (!resp_valid) begin
            if (req_busy) busy_cyc++;
            if (hold_off) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = a + 32'h4; req_wdata = 32'h5151_5151;
            end
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        rd = resp_rdata; h = resp_hit;
        nops = lg_n - base;
    endtask

    logic [31:0] rd; logic h; int lat, nops, base, bc;

    task automatic t_reset();
        chk(!req_busy && !resp_valid && !mem_req_valid, "R10 idle after reset",
            {29'd0, req_busy, resp_valid, mem_req_valid}, 32'd0);
        acc(0, 32'h48, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h == 0, "R10 first load misses", h, 0);
        chk(rd == initv(32'h48), "R7 fill returns word", rd, initv(32'h48));
        chk(nops == 8, "R7 eight fill reads", nops, 8);
        for (int i = 0; i < 8; i++)
            chk(!lg_w[base+i] && lg_a[base+i] == 32'h40 + 4*i, "R7 fill order",
                lg_a[base+i], 32'h40 + 4*i);
        acc(0, 32'h5C, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && lat == 1 && nops == 0, "R1 load hit fast, no memory",
            {h, 15'd0, 8'(lat), 8'(nops)}, {1'b1, 15'd0, 8'd1, 8'd0});
        chk(rd == initv(32'h5C), "R1 hit data", rd, initv(32'h5C));
    endtask

    task automatic t_store_hit();
        acc(1, 32'h44, 32'hDEAD_BEEF, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && lat == 1 && nops == 0, "R2 store hit local", {h, 23'd0, 8'(nops)}, {1'b1, 31'd0});
        acc(0, 32'h44, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && rd == 32'hDEAD_BEEF, "R2 store hit readback", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_writeback();
        acc(0, 32'h858, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 16, "R4 write-back plus fill count", nops, 16);
        for (int i = 0; i < 8; i++) begin
            chk(lg_w[base+i] && lg_a[base+i] == 32'h40 + 4*i, "R4 write-back order",
                lg_a[base+i], 32'h40 + 4*i);
            chk(lg_d[base+i] == ((i == 1) ? 32'hDEAD_BEEF : initv(32'h40 + 4*i)),
                "R4 write-back data", lg_d[base+i],
                (i == 1) ? 32'hDEAD_BEEF : initv(32'h40 + 4*i));
            chk(!lg_w[base+8+i] && lg_a[base+8+i] == 32'h840 + 4*i, "R4 fill after write-back",
                lg_a[base+8+i], 32'h840 + 4*i);
        end
        chk(rd == initv(32'h858), "R7 data after replacement", rd, initv(32'h858));
        acc(0, 32'h44, 0, 0, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 1 && rd == 32'hDEAD_BEEF, "R6 uncached read sees written-back word",
            rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_wthru();
        acc(0, 32'h100, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        acc(1, 32'h104, 32'h1234_5678, 1, 1, 0, rd, h, lat, nops, base, bc);
        chk(h && nops == 1, "R3 write-through single write", nops, 1);
        chk(lg_w[base] && lg_a[base] == 32'h104 && lg_d[base] == 32'h1234_5678,
            "R3 write-through content", lg_d[base], 32'h1234_5678);
        acc(0, 32'h104, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && rd == 32'h1234_5678, "R3 line updated", rd, 32'h1234_5678);
        acc(0, 32'h900, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 8 && !lg_w[base], "R3 clean eviction, no write-back", nops, 8);
    endtask

    task automatic t_disabled();
        cache_en = 1'b0;
        acc(0, 32'h844, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && nops == 0 && rd == initv(32'h844), "R5 load hit while disabled", rd, initv(32'h844));
        acc(1, 32'h848, 32'hCAFE_F00D, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && nops == 0, "R5 store hit while disabled", nops, 0);
        acc(0, 32'h848, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && rd == 32'hCAFE_F00D, "R5 store hit visible", rd, 32'hCAFE_F00D);
        for (int k = 0; k < 2; k++) begin
            acc(0, 32'h200, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
            chk(!h && nops == 1 && lg_a[base] == 32'h200 && rd == initv(32'h200),
                "R6 no allocation while disabled", nops, 1);
        end
        cache_en = 1'b1; mmu_en = 1'b0;
        acc(0, 32'h200, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 1, "R6 no allocation without mmu", nops, 1);
        mmu_en = 1'b1;
        acc(0, 32'h200, 0, 0, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 1, "R6 no allocation when uncacheable", nops, 1);
        acc(0, 32'h200, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 8, "R6 allocation when all three set", nops, 8);
    endtask

    task automatic t_store_miss();
        acc(1, 32'h300, 32'h0BAD_F00D, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 1 && lg_w[base] && lg_a[base] == 32'h300 && lg_d[base] == 32'h0BAD_F00D,
            "R8 store miss one write", nops, 1);
        acc(0, 32'h300, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 8 && rd == 32'h0BAD_F00D, "R8 store miss did not allocate", rd, 32'h0BAD_F00D);
    endtask

    task automatic t_stall_busy();
        stall = 1'b1;
        acc(0, 32'hC08, 0, 1, 0, 1, rd, h, lat, nops, base, bc);
        chk(!h && rd == initv(32'hC08), "R11 fill under stalls", rd, initv(32'hC08));
        chk(nops == 8 && bc > 0, "R9 busy and store ignored", nops, 8);
        acc(0, 32'hC0C, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(h && rd == initv(32'hC0C), "R9 ignored store left line", rd, initv(32'hC0C));
        acc(0, 32'h44, 0, 1, 0, 0, rd, h, lat, nops, base, bc);
        chk(!h && nops == 16 && lg_w[base+2] && lg_d[base+2] == 32'hCAFE_F00D,
            "R4 dirty from disabled store written back", lg_d[base+2], 32'hCAFE_F00D);
        chk(rd == 32'hDEAD_BEEF, "R11 refill data under stalls", rd, 32'hDEAD_BEEF);
        stall = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_hit();
        t_writeback();
        t_wthru();
        t_disabled();
        t_store_miss();
        t_stall_busy();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule